// File: doc/BRIEF.md
# I2C Host Bus Fault Monitor

This block sits beside an I2C host controller and watches the two open-drain lines while the host runs a transfer. It compares what the host itself drives against what the wires actually carry. It reports three separate causes of trouble. The first is a foreign device pulling SCL low while the host has released it inside its own clock-high window. The second is a foreign device pulling SDA low while the host is transmitting and has released SDA. The third is SDA changing level during a clock-high window while the host is receiving a data or acknowledge bit.

Each cause has its own sticky flag, which stays set until it is cleared by a write-one-to-clear pulse. Each flag also has an enable bit, and the interrupt line is the OR of the enabled flags. A synchronous soft-clear input returns the whole monitor to idle without a chip reset, so software can recover from an error and start again. The block only observes and reports. It never stops or alters the transfer.

Top module: `i2c_bus_guard`

## Requirements
- R1: The raw line inputs pass through a two-stage synchronizer, and a contention mismatch counts only when it is present on the synchronized value in two consecutive cycles. A low glitch lasting one cycle never sets a flag. A raw low held from edge k onward makes the flag visible after edge k+3.
- R2: Flag bit 0 (SCL contention) sets when `high_win`=1, `drv_scl`=1 and the synchronized SCL is 0, held for two consecutive cycles.
- R3: Flag bit 1 (SDA contention) sets when `high_win`=1, `rx_phase`=0, `drv_sda`=1 and the synchronized SDA is 0, held for two consecutive cycles. It never sets while `rx_phase`=1.
- R4: Flag bit 2 (SDA instability) sets when `rx_phase`=1 and `high_win` is 1 in both the current cycle and the previous cycle, and the synchronized SDA differs from its value in the previous cycle.
- R5: While `cond_gen`=1, a change on SDA never sets flag bit 2.
- R6: A set flag stays set until its bit in `clr_w1c` is 1 or `soft_clr` is 1.
- R7: If a clear pulse on a bit and a new detection of the same cause arrive in the same cycle, the flag stays set.
- R8: `irq` is 1 exactly when some flag is set and its bit in `irq_en` is 1.
- R9: `soft_clr` clears all flags and all internal history, including the synchronizer, which returns to the released level 1. Detections that follow are judged as they would be after reset.
- R10: When `high_win`=0, no flag sets, whatever the lines do.
- R11: While `rst` is 1, and in the first cycle after it, `flags` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_clr | input | 1 | Synchronous on-the-fly return to idle |
| drv_scl | input | 1 | Host SCL drive (1 = released) |
| drv_sda | input | 1 | Host SDA drive (1 = released) |
| line_scl | input | 1 | Asynchronous SCL wire level |
| line_sda | input | 1 | Asynchronous SDA wire level |
| rx_phase | input | 1 | 1 while the host receives a data or acknowledge bit |
| high_win | input | 1 | 1 during a host-generated SCL-high window |
| cond_gen | input | 1 | 1 while the host forms a START or STOP condition |
| clr_w1c | input | 3 | Per-flag clear pulse |
| irq_en | input | 3 | Per-flag interrupt enable |
| flags | output | 3 | Sticky causes: bit 0 SCL contention, bit 1 SDA contention, bit 2 SDA instability |
| irq | output | 1 | OR of enabled flags |

## Verification
A corrupted synchronizer or persistence register shows up at `flags` as a detection one cycle early, one cycle late, or a glitch wrongly accepted. The bench compares every cycle, so an off-by-one in the pipeline depth is caught on the first disturbance. A wrong previous-SDA or previous-window register shows up as a false or missing instability flag in the cycle after the window opens. A stale value left behind after a soft clear shows up on the very next window.

// File: rtl/i2c_guard_pkg.sv
package i2c_guard_pkg;

    localparam int NUM_CAUSES = 3;
    localparam int IDX_SCL_CLASH  = 0;
    localparam int IDX_SDA_CLASH  = 1;
    localparam int IDX_SDA_WOBBLE = 2;

    typedef logic [NUM_CAUSES-1:0] cause_vec_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_pair_t;

    typedef enum logic [1:0] {
        WIN_CLOSED = 2'd0,
        WIN_FIRST  = 2'd1,
        WIN_OPEN   = 2'd2
    } win_state_e;

    function automatic logic any_enabled(cause_vec_t f, cause_vec_t en);
        return |(f & en);
    endfunction

    function automatic logic released_but_low(logic drive, logic seen);
        return drive & ~seen;
    endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fault_detect.sv
module fault_detect
    import i2c_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  bus_pair_t  drv,
    input  bus_pair_t  seen,
    input  logic       rx_phase,
    input  logic       high_win,
    input  logic       cond_gen,
    output cause_vec_t hit
);
    logic       scl_mis, sda_mis;
    logic       scl_mis_q, sda_mis_q;
    logic       sda_prev;
    win_state_e win_st;

    assign scl_mis = high_win & released_but_low(drv.scl, seen.scl);
    assign sda_mis = high_win & ~rx_phase & released_but_low(drv.sda, seen.sda);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            scl_mis_q <= 1'b0;
            sda_mis_q <= 1'b0;
            sda_prev  <= 1'b1;
            win_st    <= WIN_CLOSED;
        end else begin
            scl_mis_q <= scl_mis;
            sda_mis_q <= sda_mis;
            sda_prev  <= seen.sda;
            if (!high_win)                win_st <= WIN_CLOSED;
            else if (win_st == WIN_CLOSED) win_st <= WIN_FIRST;
            else                          win_st <= WIN_OPEN;
        end
    end

    always_comb begin
        hit = '0;
        hit[IDX_SCL_CLASH]  = scl_mis & scl_mis_q;
        hit[IDX_SDA_CLASH]  = sda_mis & sda_mis_q;
        hit[IDX_SDA_WOBBLE] = high_win & (win_st != WIN_CLOSED) & rx_phase
                              & ~cond_gen & (seen.sda != sda_prev);
    end
endmodule

// File: rtl/sticky_bank.sv
module sticky_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_all,
    input  logic [N-1:0] set,
    input  logic [N-1:0] w1c,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clr_all) q[i] <= 1'b0;
            else if (set[i])    q[i] <= 1'b1;
            else if (w1c[i])    q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_bus_guard.sv
module i2c_bus_guard
    import i2c_guard_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  soft_clr,
    input  logic                  drv_scl,
    input  logic                  drv_sda,
    input  logic                  line_scl,
    input  logic                  line_sda,
    input  logic                  rx_phase,
    input  logic                  high_win,
    input  logic                  cond_gen,
    input  logic [NUM_CAUSES-1:0] clr_w1c,
    input  logic [NUM_CAUSES-1:0] irq_en,
    output logic [NUM_CAUSES-1:0] flags,
    output logic                  irq
);
    localparam int NUM_LINES = 2;

    logic [NUM_LINES-1:0] raw_vec, sync_vec;
    bus_pair_t            drv_p, seen_p;
    cause_vec_t           hit;

    assign raw_vec = {line_scl, line_sda};

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_sync
        line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk (clk),
            .rst (rst),
            .clr (soft_clr),
            .d   (raw_vec[l]),
            .q   (sync_vec[l])
        );
    end

    assign seen_p = bus_pair_t'(sync_vec);
    assign drv_p  = '{scl: drv_scl, sda: drv_sda};

    fault_detect u_det (
        .clk      (clk),
        .rst      (rst),
        .clr      (soft_clr),
        .drv      (drv_p),
        .seen     (seen_p),
        .rx_phase (rx_phase),
        .high_win (high_win),
        .cond_gen (cond_gen),
        .hit      (hit)
    );

    sticky_bank #(.N(NUM_CAUSES)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .clr_all (soft_clr),
        .set     (hit),
        .w1c     (clr_w1c),
        .q       (flags)
    );

    assign irq = any_enabled(flags, irq_en);
endmodule

// File: rtl/i2c_bus_guard_chk.sv
module i2c_bus_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       soft_clr,
    input logic       rx_phase,
    input logic       high_win,
    input logic       cond_gen,
    input logic [2:0] clr_w1c,
    input logic [2:0] irq_en,
    input logic [2:0] flags,
    input logic       irq
);
    for (genvar i = 0; i < 3; i++) begin : g_hold
        assert_flag_holds_R6: assert property (@(posedge clk) disable iff (rst)
            (flags[i] && !clr_w1c[i] && !soft_clr) |=> flags[i]);
    end

    assert_soft_clear_R9: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> (flags == 3'b000));

    assert_quiet_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (flags == 3'b000) |-> !irq);

    assert_scl_needs_window_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[0]) |-> $past(high_win));

    assert_sda_clash_tx_only_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[1]) |-> $past(high_win && !rx_phase));

    assert_wobble_rx_only_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[2]) |-> $past(high_win && rx_phase));

    assert_no_wobble_in_cond_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[2]) |-> $past(!cond_gen));
endmodule

bind i2c_bus_guard i2c_bus_guard_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .soft_clr (soft_clr),
    .rx_phase (rx_phase),
    .high_win (high_win),
    .cond_gen (cond_gen),
    .clr_w1c  (clr_w1c),
    .irq_en   (irq_en),
    .flags    (flags),
    .irq      (irq)
);

// File: tb/sim_i2c_bus_guard.sv
module sim_i2c_bus_guard;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst, soft_clr, drv_scl, drv_sda, line_scl, line_sda;
    logic       rx_phase, high_win, cond_gen;
    logic [2:0] clr_w1c, irq_en, flags;
    logic       irq;

    i2c_bus_guard u0 (
        .clk(clk), .rst(rst), .soft_clr(soft_clr), .drv_scl(drv_scl), .drv_sda(drv_sda),
        .line_scl(line_scl), .line_sda(line_sda), .rx_phase(rx_phase), .high_win(high_win),
        .cond_gen(cond_gen), .clr_w1c(clr_w1c), .irq_en(irq_en), .flags(flags), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    done = 0;
    string tag = "R11";

    // behavioural reference model
    logic q_scl[$];
    logic q_sda[$];
    int   run_scl, run_sda;
    logic prev_sda, prev_win;
    logic [2:0] m_flags;

    task automatic model_idle();
        q_scl = '{1'b1, 1'b1};
        q_sda = '{1'b1, 1'b1};
        run_scl = 0; run_sda = 0;
        prev_sda = 1'b1; prev_win = 1'b0;
        m_flags = 3'b000;
    endtask

    initial model_idle();

    always @(posedge clk) begin
        if (rst || soft_clr) begin
            model_idle();
        end else begin
            logic s_scl, s_sda, c_scl, c_sda, wob;
            logic [2:0] det;
            s_scl = q_scl[1];
            s_sda = q_sda[1];
            c_scl = high_win && drv_scl && !s_scl;
            c_sda = high_win && !rx_phase && drv_sda && !s_sda;
            wob   = high_win && prev_win && rx_phase && !cond_gen && (s_sda != prev_sda);
            det   = {wob, c_sda && run_sda > 0, c_scl && run_scl > 0};
            run_scl = c_scl ? run_scl + 1 : 0;
            run_sda = c_sda ? run_sda + 1 : 0;
            for (int i = 0; i < 3; i++) begin
                if (det[i]) m_flags[i] = 1'b1;
                else if (clr_w1c[i]) m_flags[i] = 1'b0;
            end
            prev_sda = s_sda;
            prev_win = high_win;
            void'(q_scl.pop_back()); q_scl.push_front(line_scl);
            void'(q_sda.pop_back()); q_sda.push_front(line_sda);
        end
    end

    task automatic compare();
        logic exp_irq;
        exp_irq = |(m_flags & irq_en);
        n_vec++;
        if (flags !== m_flags || irq !== exp_irq) begin
            n_bad++;
            $display("FAIL %s: flags=%b irq=%b expected flags=%b irq=%b at t=%0t",
                     tag, flags, irq, m_flags, exp_irq, $time);
        end
    endtask

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            compare();
        end
    endtask

    task automatic quiet();
        drv_scl = 1; drv_sda = 1; line_scl = 1; line_sda = 1;
        rx_phase = 0; high_win = 0; cond_gen = 0; clr_w1c = 0; soft_clr = 0;
    endtask

    task automatic wipe();
        clr_w1c = 3'b111; tick(); clr_w1c = 3'b000;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        quiet(); irq_en = 3'b111; rst = 1;
        tag = "R11"; tick(3);
        rst = 0; tick();

        // R2: SCL held low by a foreign device inside the window
        tag = "R2"; high_win = 1; line_scl = 0; tick(5);
        line_scl = 1; high_win = 0; tick(3);
        // R6: flag persists, then clears on W1C
        tag = "R6"; tick(4); clr_w1c = 3'b001; tick(); clr_w1c = 0; tick(2);

        // R1: single-cycle glitch ignored, then held low timed
        tag = "R1"; high_win = 1; line_scl = 0; tick(); line_scl = 1; tick(5);
        line_sda = 0; tick(); line_sda = 1; tick(5);
        line_scl = 0; tick(2); tick(); tick(); line_scl = 1; high_win = 0; tick(3);
        wipe();

        // R3: SDA contention only while transmitting
        tag = "R3"; high_win = 1; rx_phase = 1; line_sda = 0; tick(6);
        line_sda = 1; tick(3);
        rx_phase = 0; line_sda = 0; tick(5); line_sda = 1; high_win = 0; tick(3);
        drv_sda = 0; high_win = 1; line_sda = 0; tick(5); drv_sda = 1; line_sda = 1; high_win = 0; tick(3);
        wipe();

        // R4: SDA changes during a received bit
        tag = "R4"; rx_phase = 1; high_win = 1; tick(4); line_sda = 0; tick(4);
        high_win = 0; tick(2); wipe();
        line_sda = 1; high_win = 1; tick(); line_sda = 0; tick(4); high_win = 0; rx_phase = 0; tick(3);
        wipe(); line_sda = 1; tick(3); wipe();

        // R5: START/STOP generation masks the instability check
        tag = "R5"; rx_phase = 1; cond_gen = 1; high_win = 1; tick(3);
        line_sda = 0; tick(4); line_sda = 1; tick(4);
        cond_gen = 0; high_win = 0; rx_phase = 0; tick(3);

        // R7: clear and detection in the same cycle
        tag = "R7"; high_win = 1; line_scl = 0; clr_w1c = 3'b001; tick(8);
        clr_w1c = 0; line_scl = 1; high_win = 0; tick(3); wipe();

        // R8: interrupt masking
        tag = "R8"; high_win = 1; line_scl = 0; tick(5); line_scl = 1; high_win = 0; tick(3);
        irq_en = 3'b000; tick(2); irq_en = 3'b110; tick(2); irq_en = 3'b001; tick(2);
        irq_en = 3'b111;

        // R9: soft clear drops flags and history, next event judged freshly
        tag = "R9"; high_win = 1; line_sda = 0; tick(2);
        soft_clr = 1; tick(); soft_clr = 0; line_sda = 1; tick(2);
        line_scl = 0; tick(6); line_scl = 1; high_win = 0; tick(3);
        soft_clr = 1; tick(); soft_clr = 0; tick(3);

        // R10: disturbances outside the window
        tag = "R10"; rx_phase = 1; line_scl = 0; line_sda = 0; tick(4);
        line_sda = 1; tick(3); rx_phase = 0; line_sda = 0; tick(4);
        quiet(); tick(3);

        // random mix
        tag = "RND";
        for (int k = 0; k < 3000; k++) begin
            high_win = ($urandom_range(0, 3) != 0);
            rx_phase = ($urandom_range(0, 2) == 0);
            cond_gen = ($urandom_range(0, 9) == 0);
            drv_scl  = ($urandom_range(0, 5) != 0);
            drv_sda  = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 4) == 0) line_scl = ~line_scl;
            if ($urandom_range(0, 4) == 0) line_sda = ~line_sda;
            clr_w1c  = ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'b000;
            irq_en   = ($urandom_range(0, 19) == 0) ? 3'($urandom) : irq_en;
            soft_clr = ($urandom_range(0, 99) == 0);
            rst      = ($urandom_range(0, 499) == 0);
            tick();
        end
        rst = 0; quiet(); tick(2);
        finish_run();
    end
endmodule